// File: doc/BRIEF.md
# DRAM Bank Timing Checker

This block watches the command stream that a memory controller sends to a four-bank DDR SDRAM. It keeps its own idea of which banks hold an open row. Any command that comes sooner than a programmed minimum gap is reported. A row left open past the longest allowed time is reported, and so is a refresh interval that runs out. The controller, or a bench watching one, connects the decoded command, the bank number, the auto-precharge flag and a strobe that marks the final data beat of a write. Every spacing value is a configuration input counted in clock cycles, so one build serves every speed grade.

A gap rule of N cycles is met when the issue cycles of the two events differ by N or more. Each bank has one small down-counter per rule. The counter is loaded when the earlier event occurs and is tested when the later command arrives. Refresh spacing, bank-to-bank activation spacing and write-to-read turnaround are shared by all banks and use global counters. All rules are evaluated in the cycle of the command. The lowest-numbered broken rule is reported one clock later, as a single-cycle pulse together with a code.

Top module: `dram_bank_timing_chk`

## Requirements
- R1: After reset `viol_o` is 0, `viol_code_o` is 0 and every bit of `bank_open_o` is 0.
- R2: `cmd_i` encoding: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 auto-refresh, 7 mode-register load. One cycle after an activate, bit `bank_i` of `bank_open_o` is set. One cycle after a precharge to that bank, or a read or write with `ap_i` high to an open bank, the bit clears. Precharge-all clears every bit. State follows the commands even when they break a rule.
- R3: Code 1 (bank state) is raised by a read or write to an idle bank, an activate to an open bank, or an auto-refresh or mode-register load while any bank is open.
- R4: Code 2 is raised by a read to a bank fewer than `cfg_rcd_rd` cycles after its activate. Code 3 is raised by a write fewer than `cfg_rcd_wr` cycles after the activate.
- R5: Code 4 is raised by an activate fewer than `cfg_rc` cycles after the previous activate to the same bank. Code 5 is raised by any activate fewer than `cfg_rrd` cycles after the previous activate to any bank.
- R6: Code 6 is raised by a precharge of an open bank fewer than `cfg_ras_min` cycles after its activate. Code 7 is raised by an activate fewer than `cfg_rp` cycles after that bank was closed by a precharge or a read with auto-precharge.
- R7: Code 8 is raised by a precharge of an open bank fewer than `cfg_wr` cycles after a `wr_last_i` pulse that belongs to a write to that bank.
- R8: Code 9 is raised by a read issued while a write burst is still open (a write was issued and its `wr_last_i` has not yet come), or fewer than `cfg_wtr` cycles after a `wr_last_i` pulse.
- R9: Code 10 is raised by an activate to a bank whose write with auto-precharge has not yet seen `wr_last_i`, or that comes fewer than `cfg_dal` cycles after that pulse.
- R10: Code 11 is raised by any command other than a no-op issued fewer than `cfg_rfc` cycles after an auto-refresh.
- R11: Code 12 pulses once when a bank has stayed open `cfg_ras_max` cycles after its activate and is not closed in that cycle.
- R12: Code 13 pulses once when, starting from the first auto-refresh, `cfg_refi` cycles pass without another one. The interval then restarts.
- R13: When several rules break in the same cycle, the lowest code is reported. `viol_o` and `viol_code_o` describe the cycle before. When no rule broke, `viol_o` is 0 and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command (encoding in R2) |
| bank_i | input | BW (2) | Bank addressed by the command |
| ap_i | input | 1 | Auto-precharge flag for read and write |
| wr_last_i | input | 1 | Final data beat of the current write burst |
| cfg_rc | input | CW (8) | Same-bank activate spacing |
| cfg_ras_min | input | CW (8) | Shortest row open time |
| cfg_rp | input | CW (8) | Precharge-to-activate spacing |
| cfg_rcd_rd | input | CW (8) | Activate-to-read spacing |
| cfg_rcd_wr | input | CW (8) | Activate-to-write spacing |
| cfg_rrd | input | CW (8) | Any-bank activate spacing |
| cfg_wr | input | CW (8) | Last write beat to precharge |
| cfg_wtr | input | CW (8) | Last write beat to read |
| cfg_dal | input | CW (8) | Last beat of auto-precharge write to activate |
| cfg_rfc | input | CW (8) | Auto-refresh to next command |
| cfg_ras_max | input | LW (17) | Longest row open time |
| cfg_refi | input | LW (17) | Longest auto-refresh interval |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 4 | Lowest broken rule code |
| bank_open_o | output | NBANK (4) | Open-row flag per bank |

## Verification
The assertions assume one command per cycle, with known values from reset release onward. They also assume `bank_i` names an existing bank and `wr_last_i` arrives only after a write. Configuration values must be held steady while a command loads a counter from them. The stimulus drives every input on the falling edge from a single sequence. It changes `cfg_ras_max` and `cfg_refi` only on idle cycles before the command that loads them. Each strobe it raises follows a write it issued itself.

// File: rtl/dbt_pkg.sv
`timescale 1ns/1ps
package dbt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  // rule codes, lower value wins
  localparam int C_STATE   = 1;
  localparam int C_RCD_RD  = 2;
  localparam int C_RCD_WR  = 3;
  localparam int C_RC      = 4;
  localparam int C_RRD     = 5;
  localparam int C_RAS_MIN = 6;
  localparam int C_RP      = 7;
  localparam int C_WR      = 8;
  localparam int C_WTR     = 9;
  localparam int C_DAL     = 10;
  localparam int C_RFC     = 11;
  localparam int C_RAS_MAX = 12;
  localparam int C_REFI    = 13;
  localparam int NCODE     = 16;

  typedef struct packed {
    logic state;
    logic rcd_rd;
    logic rcd_wr;
    logic rc;
    logic ras_min;
    logic rp;
    logic wr;
    logic dal;
    logic ras_max;
  } bank_err_t;

  // a gap of n cycles: counter starts at n-1 on the next cycle and must reach 0
  function automatic logic [31:0] gap_load(input logic [31:0] n);
    return (n == 32'd0) ? 32'd0 : n - 32'd1;
  endfunction

  // lowest set rule index, 0 when none
  function automatic logic [3:0] first_code(input logic [NCODE-1:0] hits);
    logic [3:0] code;
    code = 4'd0;
    for (int i = NCODE - 1; i >= 1; i--) begin
      if (hits[i]) code = 4'(i);
    end
    return code;
  endfunction

endpackage

// File: rtl/dbt_gap_timer.sv
`timescale 1ns/1ps
module dbt_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dbt_bank.sv
`timescale 1ns/1ps
module dbt_bank
  import dbt_pkg::*;
#(
  parameter int CW = 8,
  parameter int LW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  cmd_e          cmd_i,
  input  logic          ap_i,
  input  logic          wr_last_i,
  input  logic [CW-1:0] cfg_rc,
  input  logic [CW-1:0] cfg_ras_min,
  input  logic [CW-1:0] cfg_rp,
  input  logic [CW-1:0] cfg_rcd_rd,
  input  logic [CW-1:0] cfg_rcd_wr,
  input  logic [CW-1:0] cfg_wr,
  input  logic [CW-1:0] cfg_dal,
  input  logic [LW-1:0] cfg_ras_max,
  output logic          open_o,
  output bank_err_t     err_o
);
  logic open_q, ap_pend_q, ras_armed_q;
  logic is_act, is_rd, is_wr, is_pre, close_ev, rp_start, dal_start;
  logic rcdr_busy, rcdw_busy, rc_busy, rasmin_busy, rasmax_busy, rp_busy, wr_busy, dal_busy;

  assign is_act    = sel_i && (cmd_i == CMD_ACT);
  assign is_rd     = sel_i && (cmd_i == CMD_RD);
  assign is_wr     = sel_i && (cmd_i == CMD_WR);
  assign is_pre    = (sel_i && (cmd_i == CMD_PRE)) || (cmd_i == CMD_PREA);
  assign close_ev  = open_q && (is_pre || ((is_rd || is_wr) && ap_i));
  assign rp_start  = open_q && (is_pre || (is_rd && ap_i));
  assign dal_start = wr_last_i && ap_pend_q;

  dbt_gap_timer #(.W(CW)) u_rcdr (.clk, .rst_n, .load_i(is_act),
    .val_i(CW'(gap_load(32'(cfg_rcd_rd)))), .busy_o(rcdr_busy));
  dbt_gap_timer #(.W(CW)) u_rcdw (.clk, .rst_n, .load_i(is_act),
    .val_i(CW'(gap_load(32'(cfg_rcd_wr)))), .busy_o(rcdw_busy));
  dbt_gap_timer #(.W(CW)) u_rc (.clk, .rst_n, .load_i(is_act),
    .val_i(CW'(gap_load(32'(cfg_rc)))), .busy_o(rc_busy));
  dbt_gap_timer #(.W(CW)) u_rasmin (.clk, .rst_n, .load_i(is_act),
    .val_i(CW'(gap_load(32'(cfg_ras_min)))), .busy_o(rasmin_busy));
  dbt_gap_timer #(.W(LW)) u_rasmax (.clk, .rst_n, .load_i(is_act),
    .val_i(LW'(gap_load(32'(cfg_ras_max)))), .busy_o(rasmax_busy));
  dbt_gap_timer #(.W(CW)) u_rp (.clk, .rst_n, .load_i(rp_start),
    .val_i(CW'(gap_load(32'(cfg_rp)))), .busy_o(rp_busy));
  dbt_gap_timer #(.W(CW)) u_wr (.clk, .rst_n, .load_i(wr_last_i),
    .val_i(CW'(gap_load(32'(cfg_wr)))), .busy_o(wr_busy));
  dbt_gap_timer #(.W(CW)) u_dal (.clk, .rst_n, .load_i(dal_start),
    .val_i(CW'(gap_load(32'(cfg_dal)))), .busy_o(dal_busy));

  always_comb begin
    err_o         = '0;
    err_o.state   = (is_act && open_q) || ((is_rd || is_wr) && !open_q);
    err_o.rcd_rd  = is_rd && rcdr_busy;
    err_o.rcd_wr  = is_wr && rcdw_busy;
    err_o.rc      = is_act && rc_busy;
    err_o.ras_min = is_pre && open_q && rasmin_busy;
    err_o.rp      = is_act && rp_busy;
    err_o.wr      = is_pre && open_q && wr_busy;
    err_o.dal     = is_act && (ap_pend_q || dal_busy);
    err_o.ras_max = ras_armed_q && open_q && !rasmax_busy && !close_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      ap_pend_q   <= 1'b0;
      ras_armed_q <= 1'b0;
    end else begin
      if (is_act)        open_q <= 1'b1;
      else if (close_ev) open_q <= 1'b0;
      if (is_wr && ap_i && open_q) ap_pend_q <= 1'b1;
      else if (wr_last_i)          ap_pend_q <= 1'b0;
      if (is_act)                        ras_armed_q <= 1'b1;
      else if (close_ev || err_o.ras_max) ras_armed_q <= 1'b0;
    end
  end

  assign open_o = open_q;
endmodule

// File: rtl/dram_bank_timing_chk.sv
`timescale 1ns/1ps
module dram_bank_timing_chk
  import dbt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CW    = 8,
  parameter int LW    = 17,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic [BW-1:0]    bank_i,
  input  logic             ap_i,
  input  logic             wr_last_i,
  input  logic [CW-1:0]    cfg_rc,
  input  logic [CW-1:0]    cfg_ras_min,
  input  logic [CW-1:0]    cfg_rp,
  input  logic [CW-1:0]    cfg_rcd_rd,
  input  logic [CW-1:0]    cfg_rcd_wr,
  input  logic [CW-1:0]    cfg_rrd,
  input  logic [CW-1:0]    cfg_wr,
  input  logic [CW-1:0]    cfg_wtr,
  input  logic [CW-1:0]    cfg_dal,
  input  logic [CW-1:0]    cfg_rfc,
  input  logic [LW-1:0]    cfg_ras_max,
  input  logic [LW-1:0]    cfg_refi,
  output logic             viol_o,
  output logic [3:0]       viol_code_o,
  output logic [NBANK-1:0] bank_open_o
);
  cmd_e cmd;
  logic is_act, is_rd, is_wr, is_ref, is_mrs;
  logic wr_busy_q, refi_armed_q;
  logic [BW-1:0] last_wr_bank_q;
  logic rrd_busy, rfc_busy, wtr_busy, refi_busy, refi_evt;
  logic [NCODE-1:0] hit_vec;
  logic [NBANK-1:0] open_v;
  bank_err_t errs [NBANK];
  logic viol_q;
  logic [3:0] code_q;

  assign cmd    = cmd_e'(cmd_i);
  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);
  assign is_ref = (cmd == CMD_REF);
  assign is_mrs = (cmd == CMD_MRS);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dbt_bank #(.CW(CW), .LW(LW)) u_bank (
      .clk, .rst_n,
      .sel_i(bank_i == BW'(b)), .cmd_i(cmd), .ap_i,
      .wr_last_i(wr_last_i && (last_wr_bank_q == BW'(b))),
      .cfg_rc, .cfg_ras_min, .cfg_rp, .cfg_rcd_rd, .cfg_rcd_wr,
      .cfg_wr, .cfg_dal, .cfg_ras_max,
      .open_o(open_v[b]), .err_o(errs[b]));
  end

  dbt_gap_timer #(.W(CW)) u_rrd (.clk, .rst_n, .load_i(is_act),
    .val_i(CW'(gap_load(32'(cfg_rrd)))), .busy_o(rrd_busy));
  dbt_gap_timer #(.W(CW)) u_rfc (.clk, .rst_n, .load_i(is_ref),
    .val_i(CW'(gap_load(32'(cfg_rfc)))), .busy_o(rfc_busy));
  dbt_gap_timer #(.W(CW)) u_wtr (.clk, .rst_n, .load_i(wr_last_i),
    .val_i(CW'(gap_load(32'(cfg_wtr)))), .busy_o(wtr_busy));
  dbt_gap_timer #(.W(LW)) u_refi (.clk, .rst_n, .load_i(is_ref || refi_evt),
    .val_i(LW'(gap_load(32'(cfg_refi)))), .busy_o(refi_busy));

  assign refi_evt = refi_armed_q && !refi_busy && !is_ref;

  always_comb begin
    hit_vec = '0;
    for (int b = 0; b < NBANK; b++) begin
      hit_vec[C_STATE]   = hit_vec[C_STATE]   | errs[b].state;
      hit_vec[C_RCD_RD]  = hit_vec[C_RCD_RD]  | errs[b].rcd_rd;
      hit_vec[C_RCD_WR]  = hit_vec[C_RCD_WR]  | errs[b].rcd_wr;
      hit_vec[C_RC]      = hit_vec[C_RC]      | errs[b].rc;
      hit_vec[C_RAS_MIN] = hit_vec[C_RAS_MIN] | errs[b].ras_min;
      hit_vec[C_RP]      = hit_vec[C_RP]      | errs[b].rp;
      hit_vec[C_WR]      = hit_vec[C_WR]      | errs[b].wr;
      hit_vec[C_DAL]     = hit_vec[C_DAL]     | errs[b].dal;
      hit_vec[C_RAS_MAX] = hit_vec[C_RAS_MAX] | errs[b].ras_max;
    end
    hit_vec[C_STATE] = hit_vec[C_STATE] | ((is_ref || is_mrs) && (|open_v));
    hit_vec[C_RRD]   = is_act && rrd_busy;
    hit_vec[C_WTR]   = is_rd && (wtr_busy || wr_busy_q);
    hit_vec[C_RFC]   = (cmd != CMD_NOP) && rfc_busy;
    hit_vec[C_REFI]  = refi_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy_q      <= 1'b0;
      last_wr_bank_q <= '0;
      refi_armed_q   <= 1'b0;
      viol_q         <= 1'b0;
      code_q         <= 4'd0;
    end else begin
      if (is_wr)          wr_busy_q <= 1'b1;
      else if (wr_last_i) wr_busy_q <= 1'b0;
      if (is_wr)  last_wr_bank_q <= bank_i;
      if (is_ref) refi_armed_q   <= 1'b1;
      viol_q <= |hit_vec;
      code_q <= first_code(hit_vec);
    end
  end

  assign viol_o      = viol_q;
  assign viol_code_o = code_q;
  assign bank_open_o = open_v;
endmodule

// File: rtl/dram_bank_timing_chk_sva.sv
`timescale 1ns/1ps
module dram_bank_timing_chk_sva #(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_i,
  input logic [BW-1:0]    bank_i,
  input logic             viol_o,
  input logic [3:0]       viol_code_o,
  input logic [NBANK-1:0] bank_open_o,
  input logic [15:0]      hit_vec
);
  p_quiet_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (viol_code_o == 4'd0));

  p_pulse_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (viol_code_o != 4'd0));

  p_hit_reported_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> viol_o);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1) |=> bank_open_o[$past(bank_i)]);

  p_prea_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd5) |=> (bank_open_o == '0));

  p_col_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd2 || cmd_i == 3'd3) && !bank_open_o[bank_i])
      |=> (viol_o && viol_code_o == 4'd1));

  p_ref_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i == 3'd6 || cmd_i == 3'd7) && (|bank_open_o))
      |=> (viol_code_o == 4'd1));
endmodule

bind dram_bank_timing_chk dram_bank_timing_chk_sva #(.NBANK(NBANK), .BW(BW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i),
  .viol_o(viol_o), .viol_code_o(viol_code_o), .bank_open_o(bank_open_o),
  .hit_vec(hit_vec));

// File: tb/dram_bank_timing_chk_test.sv
`timescale 1ns/1ps
module dram_bank_timing_chk_test;
  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RD = 3'd2, K_WR = 3'd3,
                         K_PRE = 3'd4, K_PREA = 3'd5, K_REF = 3'd6, K_MRS = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] cmd = 3'd0;
  logic [1:0] bank = 2'd0;
  logic ap = 1'b0, wl = 1'b0;
  logic [7:0] c_rc = 8'd6, c_rasmin = 8'd4, c_rp = 8'd3, c_rcdrd = 8'd3, c_rcdwr = 8'd2;
  logic [7:0] c_rrd = 8'd2, c_wr = 8'd2, c_wtr = 8'd2, c_dal = 8'd5, c_rfc = 8'd5;
  logic [16:0] c_rasmax = 17'd1000, c_refi = 17'd1000;
  logic viol;
  logic [3:0] code;
  logic [3:0] open;

  dram_bank_timing_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .ap_i(ap), .wr_last_i(wl),
    .cfg_rc(c_rc), .cfg_ras_min(c_rasmin), .cfg_rp(c_rp), .cfg_rcd_rd(c_rcdrd),
    .cfg_rcd_wr(c_rcdwr), .cfg_rrd(c_rrd), .cfg_wr(c_wr), .cfg_wtr(c_wtr),
    .cfg_dal(c_dal), .cfg_rfc(c_rfc), .cfg_ras_max(c_rasmax), .cfg_refi(c_refi),
    .viol_o(viol), .viol_code_o(code), .bank_open_o(open));

  typedef struct {
    logic [3:0] code;
    logic [3:0] open;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [3:0] model_open = 4'd0;
  bit done = 1'b0;

  // monitor: result of the command driven at the last falling edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (viol !== (e.code != 4'd0) || code !== e.code) begin
        n_bad++;
        $display("FAIL %s: viol/code actual %b/%0d expected %b/%0d",
                 e.tag, viol, code, (e.code != 4'd0), e.code);
      end
      n_cmp++;
      if (open !== e.open) begin
        n_bad++;
        $display("FAIL %s: bank_open actual %b expected %b", e.tag, open, e.open);
      end
    end
  end

  task automatic step(input logic [2:0] c, input int b, input logic a,
                      input logic w, input logic [3:0] exp_code, input string tag);
    exp_t e;
    @(negedge clk);
    cmd = c; bank = 2'(b); ap = a; wl = w;
    case (c)
      K_ACT:       model_open[b] = 1'b1;
      K_PRE:       model_open[b] = 1'b0;
      K_PREA:      model_open = 4'd0;
      K_RD, K_WR:  if (a) model_open[b] = 1'b0;
      default: ;
    endcase
    e.code = exp_code; e.open = model_open; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(K_NOP, 0, 1'b0, 1'b0, 4'd0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (viol !== 1'b0 || code !== 4'd0 || open !== 4'd0) begin
      n_bad++;
      $display("FAIL R1: reset actual %b/%0d/%b expected 0/0/0000", viol, code, open);
    end
    // read spacing, row time, priority
    step(K_ACT, 0, 0, 0, 4'd0,  "R2");
    step(K_RD,  0, 0, 0, 4'd2,  "R4");
    step(K_NOP, 0, 0, 0, 4'd0,  "R4");
    step(K_RD,  0, 0, 0, 4'd0,  "R4");
    step(K_PRE, 0, 0, 0, 4'd0,  "R6");
    step(K_ACT, 0, 0, 0, 4'd4,  "R13");
    step(K_PRE, 0, 0, 0, 4'd6,  "R6");
    idle(6, "R13");
    // bank spacing, write turnaround, write recovery
    step(K_ACT, 1, 0, 0, 4'd0,  "R5");
    step(K_ACT, 2, 0, 0, 4'd5,  "R5");
    step(K_WR,  1, 0, 0, 4'd0,  "R4");
    step(K_RD,  1, 0, 0, 4'd9,  "R8");
    step(K_NOP, 0, 0, 1, 4'd0,  "R8");
    step(K_PRE, 1, 0, 0, 4'd8,  "R7");
    step(K_RD,  2, 0, 0, 4'd0,  "R8");
    step(K_PREA, 0, 0, 0, 4'd0, "R2");
    idle(6, "R2");
    // idle bank, write spacing, auto-precharge recovery, refresh spacing
    step(K_RD,  3, 0, 0, 4'd1,  "R3");
    step(K_ACT, 3, 0, 0, 4'd0,  "R2");
    step(K_WR,  3, 0, 0, 4'd3,  "R4");
    step(K_NOP, 0, 0, 1, 4'd0,  "R9");
    step(K_WR,  3, 1, 0, 4'd0,  "R2");
    step(K_NOP, 0, 0, 1, 4'd0,  "R9");
    step(K_NOP, 0, 0, 0, 4'd0,  "R9");
    step(K_NOP, 0, 0, 0, 4'd0,  "R9");
    step(K_ACT, 3, 0, 0, 4'd10, "R9");
    step(K_REF, 0, 0, 0, 4'd1,  "R3");
    step(K_NOP, 0, 0, 0, 4'd0,  "R10");
    step(K_NOP, 0, 0, 0, 4'd0,  "R10");
    step(K_PRE, 3, 0, 0, 4'd11, "R10");
    idle(6, "R10");
    step(K_ACT, 0, 0, 0, 4'd0,  "R2");
    step(K_MRS, 0, 0, 0, 4'd1,  "R3");
    step(K_NOP, 0, 0, 0, 4'd0,  "R3");
    step(K_NOP, 0, 0, 0, 4'd0,  "R3");
    step(K_PRE, 0, 0, 0, 4'd0,  "R6");
    idle(4, "R11");
    // longest open time
    c_rasmax = 17'd5;
    step(K_ACT, 1, 0, 0, 4'd0,  "R11");
    idle(4, "R11");
    step(K_NOP, 0, 0, 0, 4'd12, "R11");
    step(K_NOP, 0, 0, 0, 4'd0,  "R11");
    step(K_PRE, 1, 0, 0, 4'd0,  "R11");
    c_rasmax = 17'd1000;
    // refresh interval
    c_refi = 17'd8;
    step(K_REF, 0, 0, 0, 4'd0,  "R12");
    idle(7, "R12");
    step(K_NOP, 0, 0, 0, 4'd13, "R12");
    step(K_NOP, 0, 0, 0, 4'd0,  "R12");
    step(K_REF, 0, 0, 0, 4'd0,  "R12");
    step(K_ACT, 0, 0, 0, 4'd11, "R10");
    idle(2, "R13");
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule